// File: doc/BRIEF.md
# Power Management Event Controller

This block holds the fixed power management registers of a system controller on a small word-wide register bus. A free-running counter ticks at the power management timer rate through a clock enable. Each time the counter's top bit changes, an overflow flag is raised. Status, enable and control registers combine timer, power button and suspend events into one level-sensitive system control interrupt (SCI). Firmware clears events by writing ones to the status register.

A separate two-byte command/status port serves the legacy power management path. A command byte can turn SCI mode on or off, and each command write can raise a one-cycle system management interrupt (SMI) pulse. A strobe bit in the control register decodes a suspend type into a shutdown request or a resume-with-reset request. Both requests are one-cycle pulses that the power sequencer outside the block acts on.

Top module: `pm_event_ctrl`

## Requirements
- R1: The counter is TMR_W bits wide (default 24). It advances by one on each clock where `tick_en` is high, wraps to zero, and reads at offset 0x08 zero-extended to 32 bits.
- R2: Only `pm_addr[5:0]` is decoded. Status is at 0x00, enable at 0x02 and control at 0x04, each 16 bits wide. Any other offset reads 0, so 0x42 aliases 0x02.
- R3: A write to the status register clears each bit written as 1 and leaves the other bits unchanged. An event that sets a bit in the same cycle wins over the clear.
- R4: Status bit 0 is set on each tick that changes counter bit TMR_W-1. That is every 2^(TMR_W-1) ticks, or every 0x800000 ticks by default.
- R5: `sci` is high exactly while status AND enable has any of bits 0, 5, 8 or 10 set. Other bits, such as bit 15, have no effect on it.
- R6: A control write stores the written value with bit 13 forced to 0, so bit 13 always reads back as 0.
- R7: A control write with bit 13 = 1 and bits 12:10 = 0 gives a one-cycle `shutdown_req` on the cycle after the write.
- R8: A control write with bit 13 = 1 and bits 12:10 = 1 sets status bits 15 and 8 and gives a one-cycle `reset_req` on the cycle after the write. Any other type value makes no request and leaves status unchanged.
- R9: While `pwr_btn` is high, status bit 8 is set only if enable bit 8 is set.
- R10: A write to command port select 0 stores the byte. 0xF1 sets control bit 0, 0xF0 clears it, and any other value leaves it unchanged.
- R11: Each command write gives a one-cycle `smi_pulse` on the next cycle when `smi_en` is high, and none when it is low. Writes to select 1 give no pulse.
- R12: Select 1 is an 8-bit read/write scratch byte that does not affect the command byte or the control register.
- R13: After reset the counter, all registers and both port bytes are zero, and `sci` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer-rate clock enable |
| pwr_btn | input | 1 | Power button event |
| smi_en | input | 1 | Allows SMI pulses on command writes |
| pm_wr | input | 1 | Register bus write strobe |
| pm_addr | input | ADDR_W | Register bus offset |
| pm_wdata | input | 16 | Register bus write data |
| pm_rdata | output | 32 | Register bus read data (combinational) |
| apm_wr | input | 1 | Command/status port write strobe |
| apm_sel | input | 1 | 0 = command byte, 1 = status byte |
| apm_wdata | input | 8 | Port write data |
| apm_rdata | output | 8 | Port read data (combinational) |
| sci | output | 1 | Level SCI interrupt |
| smi_pulse | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with a 10-bit counter, so the flag must rise on tick 512 and again when the counter wraps. A design keyed to a carry out of the counter would miss the first of these, and one keyed to the wrong bit would fire early. A clear that lands on the same tick as an overflow must leave the flag set; a design that lets the clear win would lose that event. The suspend strobe is checked for reading back as 0, for pulsing exactly one cycle, and for doing nothing on type values above 1. Aliased offsets and unmapped reads are checked too, so the test catches full-address decode or stale read data.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;

  localparam logic [5:0] OFS_STS  = 6'h00;
  localparam logic [5:0] OFS_EN   = 6'h02;
  localparam logic [5:0] OFS_CTL  = 6'h04;
  localparam logic [5:0] OFS_TMR  = 6'h08;

  localparam int B_TMR   = 0;
  localparam int B_GBL   = 5;
  localparam int B_BTN   = 8;
  localparam int B_RTC   = 10;
  localparam int B_RSM   = 15;
  localparam int B_SUSEN = 13;
  localparam int B_SCIEN = 0;

  localparam logic [REG_W-1:0] SCI_MASK =
    REG_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_BTN) | (1 << B_RTC));

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

  typedef enum logic [1:0] {
    SUS_NONE  = 2'd0,
    SUS_OFF   = 2'd1,
    SUS_RESET = 2'd2
  } sus_act_e;

  function automatic logic [REG_W-1:0] w1c_update(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] clr,
    input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic sci_level(
    input logic [REG_W-1:0] sts,
    input logic [REG_W-1:0] en);
    return |(sts & en & SCI_MASK);
  endfunction

  function automatic sus_act_e sus_decode(input logic [REG_W-1:0] wd);
    if (!wd[B_SUSEN]) return SUS_NONE;
    case (wd[12:10])
      3'd0:    return SUS_OFF;
      3'd1:    return SUS_RESET;
      default: return SUS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] count,
  output logic             ovf_evt
);
  localparam int LOW_W = TMR_W - 1;

  function automatic logic top_bit_flips(input logic [TMR_W-1:0] c);
    return &c[LOW_W-1:0];
  endfunction

  assign ovf_evt = tick_en & top_bit_flips(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end

  // R1
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == TMR_W'($past(count) + 1'b1));

  // R1
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  // R4
  tmr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> count[TMR_W-1] != $past(count[TMR_W-1]));
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port
  import pm_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       smi_en,
  output logic [7:0] rdata,
  output logic       sci_on,
  output logic       sci_off,
  output logic       smi_pulse
);
  logic [7:0] cmd_q, stat_q;
  logic       cmd_wr;

  assign cmd_wr  = wr & ~sel;
  assign sci_on  = cmd_wr & (wdata == CMD_SCI_ON);
  assign sci_off = cmd_wr & (wdata == CMD_SCI_OFF);
  assign rdata   = sel ? stat_q : cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      stat_q    <= '0;
      smi_pulse <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      if (wr && sel) stat_q <= wdata;
      smi_pulse <= cmd_wr & smi_en;
    end
  end

  // R11
  smi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(wr && !sel && smi_en));

  // R12
  stat_keep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel) |=> $stable(cmd_q));
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [5:0]       ofs,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             pwr_btn,
  input  logic             sci_on,
  input  logic             sci_off,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] ctl,
  output logic             sci,
  output logic             shutdown_req,
  output logic             reset_req
);
  logic             wr_sts, wr_en, wr_ctl;
  sus_act_e         sus_act;
  logic [REG_W-1:0] sts_set, sts_clr, ctl_next;

  assign wr_sts  = wr && (ofs == OFS_STS);
  assign wr_en   = wr && (ofs == OFS_EN);
  assign wr_ctl  = wr && (ofs == OFS_CTL);
  assign sus_act = wr_ctl ? sus_decode(wdata) : SUS_NONE;

  always_comb begin
    sts_set = '0;
    sts_set[B_TMR] = ovf_evt;
    sts_set[B_BTN] = (pwr_btn & en[B_BTN]) | (sus_act == SUS_RESET);
    sts_set[B_RSM] = (sus_act == SUS_RESET);
    sts_clr = wr_sts ? wdata : '0;
  end

  always_comb begin
    ctl_next = ctl;
    if (wr_ctl) begin
      ctl_next = wdata;
      ctl_next[B_SUSEN] = 1'b0;
    end
    if (sci_on)  ctl_next[B_SCIEN] = 1'b1;
    if (sci_off) ctl_next[B_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts          <= '0;
      en           <= '0;
      ctl          <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      sts          <= w1c_update(sts, sts_clr, sts_set);
      if (wr_en) en <= wdata;
      ctl          <= ctl_next;
      shutdown_req <= (sus_act == SUS_OFF);
      reset_req    <= (sus_act == SUS_RESET);
    end
  end

  assign sci = sci_level(sts, en);

  // R6
  ctl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !ctl[B_SUSEN]);

  // R7
  off_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  // R8
  rst_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> sts[B_RSM] && sts[B_BTN]);

  // R4
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_TMR]) |-> $past(ovf_evt));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> sts[B_TMR]);

  // R10
  sci_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_on |=> ctl[B_SCIEN]);

  // R9
  btn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[B_BTN]) |-> $past(en[B_BTN]) || $past(wr_ctl));

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reset_req));
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pwr_btn,
  input  logic              smi_en,
  input  logic              pm_wr,
  input  logic [ADDR_W-1:0] pm_addr,
  input  logic [15:0]       pm_wdata,
  output logic [31:0]       pm_rdata,
  input  logic              apm_wr,
  input  logic              apm_sel,
  input  logic [7:0]        apm_wdata,
  output logic [7:0]        apm_rdata,
  output logic              sci,
  output logic              smi_pulse,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam int DEC_W = 6;

  logic [DEC_W-1:0] ofs;
  logic [TMR_W-1:0] tmr_count;
  logic             ovf_evt, sci_on, sci_off;
  logic [REG_W-1:0] sts, en, ctl;

  assign ofs = pm_addr[DEC_W-1:0];

  pm_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .count(tmr_count), .ovf_evt(ovf_evt)
  );

  pm_apm_port u_apm (
    .clk(clk), .rst_n(rst_n), .wr(apm_wr), .sel(apm_sel),
    .wdata(apm_wdata), .smi_en(smi_en), .rdata(apm_rdata),
    .sci_on(sci_on), .sci_off(sci_off), .smi_pulse(smi_pulse)
  );

  pm_event_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(pm_wr), .ofs(ofs), .wdata(pm_wdata),
    .ovf_evt(ovf_evt), .pwr_btn(pwr_btn), .sci_on(sci_on), .sci_off(sci_off),
    .sts(sts), .en(en), .ctl(ctl), .sci(sci),
    .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  always_comb begin
    case (ofs)
      OFS_STS: pm_rdata = 32'(sts);
      OFS_EN:  pm_rdata = 32'(en);
      OFS_CTL: pm_rdata = 32'(ctl);
      OFS_TMR: pm_rdata = 32'(tmr_count);
      default: pm_rdata = '0;
    endcase
  end

  // R5
  sci_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[B_BTN] && en[B_BTN]) |-> sci);

  // R2
  rd_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == OFS_EN) |-> pm_rdata[15:0] == en);
endmodule

// File: tb/test_pm_event_ctrl.sv
module test_pm_event_ctrl;
  localparam int TW = 10;
  localparam int NVEC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 0, pwr_btn = 0, smi_en = 0;
  logic pm_wr = 0;
  logic [7:0] pm_addr = '0;
  logic [15:0] pm_wdata = '0;
  logic [31:0] pm_rdata;
  logic apm_wr = 0, apm_sel = 0;
  logic [7:0] apm_wdata = '0, apm_rdata;
  logic sci, smi_pulse, shutdown_req, reset_req;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pm_event_ctrl #(.TMR_W(TW), .ADDR_W(8)) i_pm_event_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_btn(pwr_btn),
    .smi_en(smi_en), .pm_wr(pm_wr), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata), .apm_wr(apm_wr), .apm_sel(apm_sel),
    .apm_wdata(apm_wdata), .apm_rdata(apm_rdata), .sci(sci),
    .smi_pulse(smi_pulse), .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  // {write, addr, data, expected read}
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 8'h08, 16'h0000, 32'h0000_0000},
    {1'b1, 8'h02, 16'h0521, 32'h0},
    {1'b0, 8'h02, 16'h0000, 32'h0000_0521},
    {1'b1, 8'h42, 16'hBEEF, 32'h0},
    {1'b0, 8'h02, 16'h0000, 32'h0000_BEEF},
    {1'b0, 8'h06, 16'h0000, 32'h0000_0000},
    {1'b0, 8'h3E, 16'h0000, 32'h0000_0000},
    {1'b1, 8'h04, 16'h0001, 32'h0},
    {1'b0, 8'h44, 16'h0000, 32'h0000_0001},
    {1'b1, 8'h04, 16'h1C07, 32'h0},
    {1'b0, 8'h04, 16'h0000, 32'h0000_1C07},
    {1'b1, 8'h04, 16'h3C02, 32'h0},
    {1'b0, 8'h04, 16'h0000, 32'h0000_1C02},
    {1'b1, 8'h00, 16'hFFFF, 32'h0},
    {1'b0, 8'h00, 16'h0000, 32'h0000_0000},
    {1'b1, 8'h02, 16'h0000, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pm_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    pm_wr = 1; pm_addr = a; pm_wdata = d;
    @(negedge clk);
    pm_wr = 0;
  endtask

  function automatic logic [31:0] rd(input logic [7:0] a);
    pm_addr = a;
    return pm_rdata;
  endfunction

  task automatic pm_read(input logic [7:0] a, output logic [31:0] v);
    pm_addr = a;
    #1 v = pm_rdata;
  endtask

  task automatic apm_write(input logic s, input logic [7:0] d);
    @(negedge clk);
    apm_wr = 1; apm_sel = s; apm_wdata = d;
    @(negedge clk);
    apm_wr = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 sci", 32'(sci), 0);
    chk("R13 pulses", {29'b0, smi_pulse, shutdown_req, reset_req}, 0);
    pm_read(8'h00, v); chk("R13 status", v, 0);
    pm_read(8'h04, v); chk("R13 control", v, 0);
    apm_sel = 0; #1 chk("R13 command byte", 32'(apm_rdata), 0);

    // R2 R6 R8 vector walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][56]) pm_write(VEC[i][55:48], VEC[i][47:32]);
      else begin
        @(negedge clk);
        pm_read(VEC[i][55:48], v);
        chk($sformatf("R2/R6 vector %0d", i), v, VEC[i][31:0]);
      end
    end
    pm_write(8'h04, 16'h0000);

    // R1 R4 timer
    ticks(5);
    pm_read(8'h08, v); chk("R1 count 5", v, 5);
    ticks(506);
    pm_read(8'h00, v); chk("R4 no flag at 511", v, 0);
    ticks(1);
    pm_read(8'h00, v); chk("R4 flag at 512", v, 1);
    pm_read(8'h08, v); chk("R1 count 512", v, 512);
    chk("R5 sci masked by enable", 32'(sci), 0);
    pm_write(8'h02, 16'h0001);
    chk("R5 sci on timer flag", 32'(sci), 1);
    pm_write(8'h00, 16'h0001);
    pm_read(8'h00, v); chk("R3 write-one clears", v, 0);
    chk("R5 sci drops", 32'(sci), 0);
    ticks(511);
    pm_read(8'h08, v); chk("R1 count 1023", v, 1023);
    @(negedge clk);
    tick_en = 1; pm_wr = 1; pm_addr = 8'h00; pm_wdata = 16'h0001;
    @(negedge clk);
    tick_en = 0; pm_wr = 0;
    pm_read(8'h00, v); chk("R3 set wins over clear at wrap", v, 1);
    pm_read(8'h08, v); chk("R1 wrap to zero", v, 0);
    pm_write(8'h00, 16'hFFFF);
    pm_write(8'h02, 16'h0000);

    // R9 power button
    @(negedge clk); pwr_btn = 1; @(negedge clk); pwr_btn = 0;
    pm_read(8'h00, v); chk("R9 button ignored when disabled", v, 0);
    pm_write(8'h02, 16'h0100);
    @(negedge clk); pwr_btn = 1; @(negedge clk); pwr_btn = 0;
    pm_read(8'h00, v); chk("R9 button sets bit 8", v, 32'h100);
    chk("R5 sci on button", 32'(sci), 1);
    pm_write(8'h00, 16'h0100);
    pm_read(8'h00, v); chk("R3 clear bit 8", v, 0);

    // R7 shutdown
    pm_write(8'h02, 16'h8000);
    pm_write(8'h04, 16'h2000);
    chk("R7 shutdown pulse", {30'b0, shutdown_req, reset_req}, 32'b10);
    @(negedge clk);
    chk("R7 shutdown one cycle", 32'(shutdown_req), 0);
    pm_read(8'h04, v); chk("R6 strobe reads 0", v, 0);

    // R8 resume with reset
    pm_write(8'h04, 16'h2400);
    chk("R8 reset pulse", {30'b0, shutdown_req, reset_req}, 32'b01);
    pm_read(8'h00, v); chk("R8 status 15 and 8", v, 32'h8100);
    chk("R5 bit 15 not an SCI source", 32'(sci), 0);
    @(negedge clk);
    chk("R8 reset one cycle", 32'(reset_req), 0);
    pm_write(8'h00, 16'hFFFF);
    pm_write(8'h04, 16'h2800);
    chk("R8 type 2 no request", {30'b0, shutdown_req, reset_req}, 0);
    pm_read(8'h00, v); chk("R8 type 2 status unchanged", v, 0);
    pm_read(8'h04, v); chk("R6 type 2 stored", v, 32'h0800);

    // R10 R11 R12 command port
    smi_en = 1;
    apm_write(0, 8'hF1);
    chk("R11 smi pulse", 32'(smi_pulse), 1);
    pm_read(8'h04, v); chk("R10 sci enable set", v, 32'h0801);
    apm_sel = 0; #1 chk("R10 command stored", 32'(apm_rdata), 32'hF1);
    @(negedge clk);
    chk("R11 smi one cycle", 32'(smi_pulse), 0);
    smi_en = 0;
    apm_write(0, 8'hF0);
    chk("R11 no smi when disabled", 32'(smi_pulse), 0);
    pm_read(8'h04, v); chk("R10 sci enable cleared", v, 32'h0800);
    smi_en = 1;
    apm_write(1, 8'h5A);
    chk("R11 no smi on status byte", 32'(smi_pulse), 0);
    apm_sel = 1; #1 chk("R12 status byte", 32'(apm_rdata), 32'h5A);
    apm_sel = 0; #1 chk("R12 command untouched", 32'(apm_rdata), 32'hF0);
    pm_read(8'h04, v); chk("R12 control untouched", v, 32'h0800);
    apm_write(0, 8'h33);
    pm_read(8'h04, v); chk("R10 other command keeps bit 0", v, 32'h0800);
    chk("R11 smi on other command", 32'(smi_pulse), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule